// File: doc/BRIEF.md
# Vectored Interrupt Controller with Register Access

This block gathers up to 32 interrupt request lines into one request line for a processor. Each line is given a trigger type by a fixed parameter mask: level or rising edge. Requests are latched into a status register. An enable register masks them, and the masked result is the pending set. A priority encoder returns the index of the lowest-numbered pending line as a vector.

Software reaches eight 32-bit word registers through a simple register bus. Writes are synchronous. Reads are combinational from the selected register. The status register can be written directly while hardware capture is off, which lets software inject interrupts for testing. While capture is on, the pins drive the status register and software writes to it are dropped. Enable bits have a write-one-to-set alias and a write-one-to-clear alias. A separate acknowledge register clears status bits with write-one-to-clear semantics.

Register byte offsets, which software decodes: 0x00 status, 0x04 pending, 0x08 enable, 0x0C acknowledge, 0x10 enable-set, 0x14 enable-clear, 0x18 vector, 0x1C control. Control bit 0 gates the output. Control bit 1 turns on hardware capture. Each pin passes through a two-flop synchronizer.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, status, enable and control read 0, the vector reads 0xFFFFFFFF and irq_out is 0.
- R2: Writing the acknowledge register (0x0C) clears each status bit whose write-data bit is 1 and leaves the other status bits unchanged.
- R3: Writing 0x10 ORs the data into enable. Writing 0x14 clears the enable bits whose data bit is 1. Writing 0x08 loads enable directly.
- R4: The control register (0x1C) stores only data bits 1:0. Its other read bits are 0.
- R5: A write to status (0x00) loads the data when control bit 1 is 0. When control bit 1 is 1, the write is ignored.
- R6: With control bit 1 set, a high level-type input (mask bit 0) sets its status bit, visible on the third rising edge after the pin changes. With control bit 1 clear, it sets nothing.
- R7: An edge-type input (mask bit 1) sets its status bit only on a 0-to-1 transition while control bit 1 is set. Holding the input high does not set the bit again after an acknowledge. A rise that happened while capture was off is not seen later.
- R8: The pending register (0x04) always reads status AND enable, and writes to it are ignored.
- R9: The vector register (0x18) reads the index of the lowest-numbered pending bit, or 0xFFFFFFFF when none is pending.
- R10: irq_out is 1 exactly when control bit 0 is 1 and at least one pending bit is set.
- R11: If a hardware set and an acknowledge clear hit the same status bit in the same cycle, the bit ends up set.
- R12: Reads of 0x0C, 0x10 and 0x14 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_in | input | NSRC | Interrupt request pins, asynchronous |
| bus_wr_en | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Byte address; bits 4:2 select the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register, combinational |
| irq_out | output | 1 | Interrupt request to the processor |

## Verification
A register write takes effect at the rising edge that samples bus_wr_en. The new value then shows on bus_rdata, on the pending set, on the vector and on irq_out in that same cycle, because the read path and the output are combinational from the registers. A pin change passes two synchronizer flops before the status register captures it, so it shows on the third rising edge after it is driven. The bench drives every input just after a falling edge. It waits one edge after a write and four edges after a pin change, then samples at the next falling edge. No sample therefore falls on a cycle where a result may still be in flight.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int DATA_W = 32;
    localparam int CTRL_W = 2;

    typedef enum logic [2:0] {
        SEL_STAT  = 3'd0,
        SEL_PEND  = 3'd1,
        SEL_ENAB  = 3'd2,
        SEL_ACK   = 3'd3,
        SEL_ENSET = 3'd4,
        SEL_ENCLR = 3'd5,
        SEL_VEC   = 3'd6,
        SEL_CTRL  = 3'd7
    } reg_sel_e;
endpackage

// File: rtl/irqc_capture.sv
module irqc_capture #(
    parameter int          NSRC      = 32,
    parameter int          STAGES    = 2,
    parameter logic [NSRC-1:0] EDGE_MASK = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hw_en,
    input  logic [NSRC-1:0] irq_in,
    output logic [NSRC-1:0] set_o
);
    logic [STAGES-1:0][NSRC-1:0] sync_d, sync_q;
    logic [NSRC-1:0]             prev_d, prev_q;
    logic [NSRC-1:0]             lvl_hit, rise_hit, cur;

    always_comb begin
        sync_d[0] = irq_in;
        for (int i = 1; i < STAGES; i++) begin
            sync_d[i] = sync_q[i-1];
        end
        prev_d   = sync_q[STAGES-1];
        cur      = sync_q[STAGES-1];
        lvl_hit  = cur & ~EDGE_MASK;
        rise_hit = cur & ~prev_q & EDGE_MASK;
        set_o    = hw_en ? (lvl_hit | rise_hit) : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            sync_q <= sync_d;
            prev_q <= prev_d;
        end
    end
endmodule

// File: rtl/irqc_prio.sv
module irqc_prio #(
    parameter int NSRC  = 32,
    localparam int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic [NSRC-1:0]  req,
    output logic             valid,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        valid = 1'b0;
        idx   = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (req[i]) begin
                valid = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
    import irqc_pkg::*;
#(
    parameter int              NSRC      = 32,
    parameter int              ADDR_W    = 5,
    parameter int              STAGES    = 2,
    parameter logic [NSRC-1:0] EDGE_MASK = 32'hFFFF_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   irq_in,
    input  logic              bus_wr_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_out
);
    localparam int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1;

    typedef struct packed {
        logic [NSRC-1:0]   stat;
        logic [NSRC-1:0]   enab;
        logic [CTRL_W-1:0] ctrl;
    } regs_t;

    regs_t           cur_d, cur_q;
    logic [NSRC-1:0] hw_set, pend, wmask;
    logic            vec_valid;
    logic [IDX_W-1:0] vec_idx;
    reg_sel_e        sel;

    assign sel   = reg_sel_e'(bus_addr[4:2]);
    assign wmask = bus_wdata[NSRC-1:0];

    irqc_capture #(.NSRC(NSRC), .STAGES(STAGES), .EDGE_MASK(EDGE_MASK)) u_cap (
        .clk    (clk),
        .rst_n  (rst_n),
        .hw_en  (cur_q.ctrl[1]),
        .irq_in (irq_in),
        .set_o  (hw_set)
    );

    irqc_prio #(.NSRC(NSRC)) u_prio (
        .req   (pend),
        .valid (vec_valid),
        .idx   (vec_idx)
    );

    always_comb begin
        cur_d = cur_q;
        if (bus_wr_en) begin
            case (sel)
                SEL_STAT:  if (!cur_q.ctrl[1]) cur_d.stat = wmask;
                SEL_ACK:   cur_d.stat = cur_q.stat & ~wmask;
                SEL_ENAB:  cur_d.enab = wmask;
                SEL_ENSET: cur_d.enab = cur_q.enab | wmask;
                SEL_ENCLR: cur_d.enab = cur_q.enab & ~wmask;
                SEL_CTRL:  cur_d.ctrl = bus_wdata[CTRL_W-1:0];
                default:   ;
            endcase
        end
        // hardware set applied last so it wins over an acknowledge
        cur_d.stat = cur_d.stat | hw_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= cur_d;
    end

    always_comb begin
        pend    = cur_q.stat & cur_q.enab;
        irq_out = cur_q.ctrl[0] && (|pend);
        case (sel)
            SEL_STAT: bus_rdata = DATA_W'(cur_q.stat);
            SEL_PEND: bus_rdata = DATA_W'(pend);
            SEL_ENAB: bus_rdata = DATA_W'(cur_q.enab);
            SEL_VEC:  bus_rdata = vec_valid ? DATA_W'(vec_idx) : '1;
            SEL_CTRL: bus_rdata = DATA_W'(cur_q.ctrl);
            default:  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk
    import irqc_pkg::*;
#(
    parameter int NSRC  = 32,
    localparam int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr_en,
    input logic [2:0]        sel,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [NSRC-1:0]   stat_q,
    input logic [NSRC-1:0]   enab_q,
    input logic [CTRL_W-1:0] ctrl_q,
    input logic [NSRC-1:0]   pend,
    input logic              vec_valid,
    input logic [IDX_W-1:0]  vec_idx,
    input logic              irq_out
);
    // R2
    ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en && sel == 3'd3 && !ctrl_q[1]) |=>
        ((stat_q & $past(bus_wdata[NSRC-1:0])) == '0));

    // R3
    enset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en && sel == 3'd4) |=>
        ((enab_q & $past(bus_wdata[NSRC-1:0])) == $past(bus_wdata[NSRC-1:0])));

    // R4
    ctrl_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == 3'd7) |-> (bus_rdata[DATA_W-1:CTRL_W] == '0));

    // R5
    stat_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en && sel == 3'd0 && ctrl_q[1]) |=>
        ((stat_q & $past(stat_q)) == $past(stat_q)));

    // R9
    vec_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> pend[vec_idx]);

    // R10
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> (ctrl_q[0] && vec_valid));
endmodule

bind irq_vector_ctrl irqc_chk #(.NSRC(NSRC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr_en (bus_wr_en),
    .sel       (bus_addr[4:2]),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .stat_q    (cur_q.stat),
    .enab_q    (cur_q.enab),
    .ctrl_q    (cur_q.ctrl),
    .pend      (pend),
    .vec_valid (vec_valid),
    .vec_idx   (vec_idx),
    .irq_out   (irq_out)
);

// File: tb/sim_irq_vector_ctrl.sv
`timescale 1ns/1ps
module sim_irq_vector_ctrl;
    localparam logic [4:0] A_STAT = 5'h00, A_PEND = 5'h04, A_ENAB = 5'h08, A_ACK = 5'h0C,
                           A_ENSET = 5'h10, A_ENCLR = 5'h14, A_VEC = 5'h18, A_CTRL = 5'h1C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] irq_in = '0;
    logic        bus_wr_en = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_out;
    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    irq_vector_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_wr_en(bus_wr_en),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr_en = 1'b1;
        @(negedge clk);
        bus_wr_en = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [4:0] a, input logic [31:0] exp);
        bus_addr = a;
        #0.5;
        check(req, bus_rdata, exp);
    endtask

    task automatic wait_pin();
        repeat (4) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        rd_chk("R1 stat", A_STAT, 32'h0);
        rd_chk("R1 enab", A_ENAB, 32'h0);
        rd_chk("R1 ctrl", A_CTRL, 32'h0);
        rd_chk("R1 vec", A_VEC, 32'hFFFF_FFFF);
        check("R1 irq_out", {31'b0, irq_out}, 32'h0);
    endtask

    task automatic t_soft_regs();
        wr(A_STAT, 32'h0000_00A0);
        rd_chk("R5 sw write", A_STAT, 32'h0000_00A0);
        rd_chk("R8 pend masked", A_PEND, 32'h0);
        wr(A_PEND, 32'h5);
        rd_chk("R8 pend write ignored", A_PEND, 32'h0);
        wr(A_ENSET, 32'h0000_00F0);
        rd_chk("R3 set", A_ENAB, 32'h0000_00F0);
        wr(A_ENSET, 32'h3);
        rd_chk("R3 set or", A_ENAB, 32'h0000_00F3);
        wr(A_ENCLR, 32'h30);
        rd_chk("R3 clear", A_ENAB, 32'h0000_00C3);
        rd_chk("R8 pend", A_PEND, 32'h0000_0080);
        rd_chk("R9 vec 7", A_VEC, 32'd7);
        check("R10 gated off", {31'b0, irq_out}, 32'h0);
        wr(A_CTRL, 32'hFFFF_FFFD);
        rd_chk("R4 ctrl bits", A_CTRL, 32'h1);
        check("R10 on", {31'b0, irq_out}, 32'h1);
        rd_chk("R12 ack read", A_ACK, 32'h0);
        rd_chk("R12 enset read", A_ENSET, 32'h0);
        rd_chk("R12 enclr read", A_ENCLR, 32'h0);
    endtask

    task automatic t_ack_vec();
        wr(A_ACK, 32'h80);
        rd_chk("R2 ack", A_STAT, 32'h20);
        rd_chk("R9 none", A_VEC, 32'hFFFF_FFFF);
        check("R10 none pending", {31'b0, irq_out}, 32'h0);
        wr(A_STAT, 32'h3);
        rd_chk("R9 vec 0", A_VEC, 32'd0);
        wr(A_ENAB, 32'hFFFF_FFFF);
        rd_chk("R3 direct load", A_ENAB, 32'hFFFF_FFFF);
        wr(A_STAT, 32'h8000_0000);
        rd_chk("R9 vec 31", A_VEC, 32'd31);
        wr(A_STAT, 32'h0001_0400);
        rd_chk("R9 vec 10", A_VEC, 32'd10);
        wr(A_ACK, 32'h0000_0400);
        rd_chk("R2 ack keeps other", A_STAT, 32'h0001_0000);
        wr(A_STAT, 32'h0);
    endtask

    task automatic t_level();
        wr(A_CTRL, 32'h3);
        wr(A_STAT, 32'h0F);
        rd_chk("R5 write ignored", A_STAT, 32'h0);
        irq_in[2] = 1'b1;
        wait_pin();
        rd_chk("R6 level set", A_STAT, 32'h4);
        check("R10 level irq", {31'b0, irq_out}, 32'h1);
        wr(A_ACK, 32'h4);
        rd_chk("R11 set wins", A_STAT, 32'h4);
        wr(A_CTRL, 32'h1);
        wr(A_ACK, 32'h4);
        wait_pin();
        rd_chk("R6 capture off", A_STAT, 32'h0);
        irq_in[2] = 1'b0;
        wait_pin();
    endtask

    task automatic t_edge();
        wr(A_CTRL, 32'h3);
        irq_in[20] = 1'b1;
        wait_pin();
        rd_chk("R7 rise", A_STAT, 32'h0010_0000);
        rd_chk("R9 vec 20", A_VEC, 32'd20);
        wr(A_ACK, 32'h0010_0000);
        wait_pin();
        rd_chk("R7 held high", A_STAT, 32'h0);
        irq_in[20] = 1'b0;
        wr(A_CTRL, 32'h1);
        irq_in[21] = 1'b1;
        wait_pin();
        rd_chk("R7 capture off", A_STAT, 32'h0);
        wr(A_CTRL, 32'h3);
        wait_pin();
        rd_chk("R7 stale rise", A_STAT, 32'h0);
        irq_in[21] = 1'b0;
        wait_pin();
        irq_in[21] = 1'b1;
        wait_pin();
        rd_chk("R7 new rise", A_STAT, 32'h0020_0000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_soft_regs();
        t_ack_vec();
        t_level();
        t_edge();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule